// File: doc/BRIEF.md
# Congestion-Gated Round-Robin Output Arbiter

One instance of this block sits at each output port of a crossbar switch. Every ingress queue on the die raises one request bit toward it. The block picks one winner in round-robin order and presents a one-hot grant that steers the crossbar. It keeps that grant until the datapath reports the end of the transfer with a single-cycle done pulse.

When the output buffer behind the port signals almost-full, the grant is masked to zero in the same cycle. No new arbitration starts while the signal is high. The rotation pointer is not touched during that time, so the port is shut off instead of pushing back on the fabric. Requests simply stay pending at ingress. When the buffer drains, service resumes in exactly the order that was in force before the blockage.

The pointer holds the index of the most recently completed winner. The next search starts just below that index and moves downward, wrapping from index 0 to the highest index. The last winner itself is therefore the lowest-priority candidate.

Top module: `cgrr_arbiter`

## Requirements
- R1: While reset is held, and until the first arbitration after reset, `grant_o` is all zeros and `grant_valid_o` is low.
- R2: `grant_o` has at most one bit set, only at an index whose request bit is high, and `grant_valid_o` is high exactly when `grant_o` is non-zero.
- R3: If the last completed winner is index j, the new winner is the first requesting index met when scanning j-1, j-2, and so on downward.
- R4: The downward scan wraps from index 0 to index NUM_REQ-1. The pointer is 0 after reset, so with every input requesting, the first winner is index NUM_REQ-1.
- R5: If the only requester is the last completed winner, that input is granted again.
- R6: While `almost_full_i` is high, `grant_o` is zero and `grant_valid_o` is low in that same cycle, and no new arbitration is started.
- R7: The pointer does not move while `almost_full_i` is high. After it falls, a grant that was pending reappears unchanged, or the next winner follows the order from before the blockage.
- R8: Once issued, a grant keeps the same index on every cycle until a done pulse is accepted. The only exception is that it is masked while almost-full is high.
- R9: `xfer_done_i` is accepted only in a cycle where `grant_valid_o` is high. Acceptance moves the pointer to the granted index, and the grant drops on the next cycle. A done pulse at any other time has no effect.
- R10: With no requests pending, no grant is issued and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | NUM_REQ | One request bit per ingress queue |
| almost_full_i | input | 1 | Output buffer near capacity; blocks and masks the grant |
| xfer_done_i | input | 1 | One-cycle pulse marking the end of the granted transfer |
| grant_o | output | NUM_REQ | One-hot grant to the crossbar |
| grant_valid_o | output | 1 | High while a grant is presented |

## Verification
The assertions assume that an ingress queue keeps its request high from the moment it is granted until its done pulse is accepted. The check that a grant only goes to a requester depends on that assumption. The stimulus follows it: request vectors are changed only on idle cycles between transfers. Every done pulse lasts exactly one cycle. Done pulses are also driven deliberately while the grant is masked and while nothing is granted, to show they are ignored.

// File: rtl/cgrr_pkg.sv
package cgrr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/cgrr_reset_sync.sv
module cgrr_reset_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cgrr_pick.sv
// Downward round-robin search: starting below last_idx, wrapping at 0,
// last_idx itself is examined last.
module cgrr_pick #(
  parameter int NUM_REQ = 8,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] req,
  input  logic [IDX_W-1:0]   last_idx,
  output logic               found,
  output logic [IDX_W-1:0]   win_idx
);
  int pos;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    pos     = 0;
    // Walk from the farthest candidate to the nearest; the nearest hit is kept.
    for (int k = NUM_REQ; k >= 1; k--) begin
      pos = (int'(last_idx) + NUM_REQ - k) % NUM_REQ;
      if (req[pos]) begin
        found   = 1'b1;
        win_idx = IDX_W'(pos);
      end
    end
  end
endmodule

// File: rtl/cgrr_slot.sv
module cgrr_slot
  import cgrr_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             found,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             blocked,
  input  logic             done,
  output logic             busy,
  output logic [IDX_W-1:0] hold_idx,
  output logic [IDX_W-1:0] ptr
);
  arb_state_e       st_q, st_d;
  logic [IDX_W-1:0] hold_q, ptr_q;
  logic             start_arb, finish_xfer;

  always_comb begin
    start_arb   = (st_q == ST_IDLE) && !blocked && found;
    finish_xfer = (st_q == ST_HOLD) && !blocked && done;
    st_d        = st_q;
    if (start_arb)   st_d = ST_HOLD;
    if (finish_xfer) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= '0;
    else if (start_arb) hold_q <= win_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ptr_q <= '0;
    else if (finish_xfer) ptr_q <= hold_q;
  end

  assign busy     = (st_q == ST_HOLD);
  assign hold_idx = hold_q;
  assign ptr      = ptr_q;
endmodule

// File: rtl/cgrr_arbiter.sv
module cgrr_arbiter #(
  parameter int NUM_REQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               almost_full_i,
  input  logic               xfer_done_i,
  output logic [NUM_REQ-1:0] grant_o,
  output logic               grant_valid_o
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic             rst_int_n;
  logic             found, busy;
  logic [IDX_W-1:0] win_idx, hold_idx, ptr;

  cgrr_reset_sync u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  cgrr_pick #(.NUM_REQ(NUM_REQ)) u_pick (
    .req      (req_i),
    .last_idx (ptr),
    .found    (found),
    .win_idx  (win_idx)
  );

  cgrr_slot #(.NUM_REQ(NUM_REQ)) u_slot (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .found    (found),
    .win_idx  (win_idx),
    .blocked  (almost_full_i),
    .done     (xfer_done_i),
    .busy     (busy),
    .hold_idx (hold_idx),
    .ptr      (ptr)
  );

  // Congestion gate: held grant is masked while the buffer is near full.
  assign grant_valid_o = busy && !almost_full_i;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_grant
    assign grant_o[g] = grant_valid_o && (hold_idx == IDX_W'(g));
  end
endmodule

// File: rtl/cgrr_arbiter_chk.sv
module cgrr_arbiter_chk #(
  parameter int NUM_REQ = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] req_i,
  input logic               almost_full_i,
  input logic               xfer_done_i,
  input logic [NUM_REQ-1:0] grant_o,
  input logic               grant_valid_o
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R2

  AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~req_i) == '0); // R2

  AST_VALID_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o == (grant_o != '0)); // R2

  AST_FULL_MASKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    almost_full_i |-> (grant_o == '0)); // R6

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && !xfer_done_i) |=> (almost_full_i || grant_o == $past(grant_o))); // R8

  AST_DONE_DROPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && xfer_done_i) |=> !grant_valid_o); // R9

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0 && !grant_valid_o) |=> !grant_valid_o); // R10
endmodule

bind cgrr_arbiter cgrr_arbiter_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_i         (req_i),
  .almost_full_i (almost_full_i),
  .xfer_done_i   (xfer_done_i),
  .grant_o       (grant_o),
  .grant_valid_o (grant_valid_o)
);

// File: tb/cgrr_arbiter_test.sv
module cgrr_arbiter_test;
  localparam int N       = 8;
  localparam int CLK_PER = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_i;
  logic         almost_full_i;
  logic         xfer_done_i;
  logic [N-1:0] grant_o;
  logic         grant_valid_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  cgrr_arbiter #(.NUM_REQ(N)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .almost_full_i (almost_full_i),
    .xfer_done_i   (xfer_done_i),
    .grant_o       (grant_o),
    .grant_valid_o (grant_valid_o)
  );

  task automatic chk(string tag, logic [N-1:0] exp_g, logic exp_v);
    n_checks++;
    if (grant_o !== exp_g || grant_valid_o !== exp_v) begin
      n_errors++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
               tag, grant_o, grant_valid_o, exp_g, exp_v);
    end
  endtask

  // Accept the current grant with a one-cycle done pulse; grant must then drop.
  task automatic finish_xfer(string tag);
    xfer_done_i = 1'b1;
    @(negedge clk);
    xfer_done_i = 1'b0;
    chk(tag, '0, 1'b0);
  endtask

  // Present a request vector, expect a given winner held for some cycles.
  task automatic do_grant(string tag, logic [N-1:0] req, int exp_idx, int hold);
    req_i = req;
    @(negedge clk);
    for (int c = 0; c <= hold; c++) begin
      chk(tag, N'(1) << exp_idx, 1'b1);
      @(negedge clk);
    end
    finish_xfer({tag, " drop"});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_i = '0; almost_full_i = 1'b0; xfer_done_i = 1'b0;
    #1 rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", '0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", '0, 1'b0);
  endtask

  task automatic t_full_rotation();
    // Pointer 0 after reset: R4 wrap gives N-1 first, then R3 descending order.
    do_grant("R4 first winner after reset", '1, N-1, 2);
    for (int w = N-2; w >= 0; w--) do_grant("R3 descending rotation", '1, w, 0);
    do_grant("R4 wrap 0 to top", '1, N-1, 0);
  endtask

  task automatic t_sparse();
    // Requests at 0,2,5; pointer 7.
    do_grant("R3 sparse from 7", 8'b0010_0101, 5, 0);
    do_grant("R3 sparse from 5", 8'b0010_0101, 2, 0);
    do_grant("R3 sparse from 2", 8'b0010_0101, 0, 0);
    do_grant("R4 sparse wrap from 0", 8'b0010_0101, 5, 0);
  endtask

  task automatic t_sole();
    do_grant("R5 sole requester is last winner", 8'b0010_0000, 5, 1);
  endtask

  task automatic t_block_before_grant();
    req_i = '1; almost_full_i = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R6 blocked before grant", '0, 1'b0);
    end
    almost_full_i = 1'b0;
    @(negedge clk);
    chk("R7 resume with frozen pointer 5", 8'b0001_0000, 1'b1);
    finish_xfer("R9 done after resume");
  endtask

  task automatic t_block_during_grant();
    req_i = 8'b0000_1001;
    @(negedge clk);
    chk("R3 winner 3 from pointer 4", 8'b0000_1000, 1'b1);
    almost_full_i = 1'b1;
    #1 chk("R6 same-cycle mask", '0, 1'b0);
    @(negedge clk);
    xfer_done_i = 1'b1;
    @(negedge clk);
    xfer_done_i = 1'b0;
    chk("R6 still masked", '0, 1'b0);
    almost_full_i = 1'b0;
    #1 chk("R9 done while masked ignored, grant returns", 8'b0000_1000, 1'b1);
    @(negedge clk);
    chk("R8 grant still held", 8'b0000_1000, 1'b1);
    finish_xfer("R9 accepted done");
    do_grant("R7 order kept after block", 8'b0000_1001, 0, 0);
  endtask

  task automatic t_idle();
    req_i = '0;
    @(negedge clk);
    xfer_done_i = 1'b1;
    @(negedge clk);
    xfer_done_i = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk("R10 idle no grant", '0, 1'b0);
      @(negedge clk);
    end
    // Pointer still 0: full request set must yield N-1.
    do_grant("R10 pointer kept while idle", '1, N-1, 0);
  endtask

  initial begin
    t_reset();
    t_full_rotation();
    t_sparse();
    t_sole();
    t_block_before_grant();
    t_block_during_grant();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule